// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of dedicated interrupt pins and turns pin activity into interrupt requests. Each pin has its own 2-bit sense selector that picks one of four conditions: a low level, any edge, a falling edge or a rising edge. The pin's enable bit must be set for the condition to be recorded or requested.

Edge conditions go through a synchronizer that advances only while the I/O clock enable is high. A detected edge sets a sticky per-pin flag. The flag drives the request until software clears it with a strobe or the interrupt is acknowledged. A low level is not latched. It requests an interrupt only while the pin is actually low and the I/O clock runs.

Separately, an asynchronous wake output rises as soon as an enabled low-level pin is low, even with the I/O clock stopped. If the low level goes away before the clock restarts, the part still wakes but no request appears. Because only the pin value is sensed, software can raise an interrupt by driving a pin it owns as an output.

Top module: `ext_irq_sense`

## Requirements
- R1: Sense selector encoding per pin is 2'b00 low level, 2'b01 any edge, 2'b10 falling edge, 2'b11 rising edge. Pin i uses bits [2i+1:2i] of `sense_mode`. In an edge mode, a matching edge on an enabled pin sets `flags[i]` at the third rising clock edge after the pin changes, with `io_clk_en` high throughout.
- R2: In low-level mode, `irq_req[i]` is high while the enabled pin is low, starting at the second clock edge after the pin falls. It drops at the second edge after the pin rises. It never sets `flags[i]`.
- R3: A set flag stays set and drives `irq_req[i]` while the pin is enabled. It is cleared at the next clock edge by `flag_clear[i]` or `irq_ack[i]`.
- R4: A pin whose enable bit is low sets no flag, raises no request and causes no wake. An edge seen while the pin is disabled is not remembered.
- R5: Edges are detected only while `io_clk_en` is high. A pulse that starts and ends while the clock is halted leaves no flag.
- R6: `wake_req` is combinational and independent of the clock. It is high whenever some enabled pin in low-level mode has its raw input low, including while `io_clk_en` is low.
- R7: A low-level request needs `io_clk_en` high. If the low level disappears before the clock resumes, the wake occurs but `irq_req` never rises.
- R8: While reset is active, `flags`, `irq_req` and the edge history are cleared. The synchronizer reads high, so pins held high create no edge on release.
- R9: When a flag set and a flag clear fall in the same clock cycle, the set wins and the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_clk_en | input | 1 | High while the I/O clock is running |
| pin_raw | input | NUM_PINS | Raw interrupt pin levels |
| sense_mode | input | 2*NUM_PINS | Per-pin 2-bit sense selector |
| irq_enable | input | NUM_PINS | Per-pin enable |
| flag_clear | input | NUM_PINS | Per-pin flag clear strobe, active high |
| irq_ack | input | NUM_PINS | Per-pin interrupt acknowledge |
| flags | output | NUM_PINS | Sticky edge flags |
| irq_req | output | NUM_PINS | Per-pin interrupt requests |
| wake_req | output | 1 | Asynchronous wake request from enabled low-level pins |

## Verification
A stale synchronizer or history bit shows up as a phantom or missing flag at the third edge after a pin change. It can also show as a level request that lingers for two edges after the pin rises. A flag register that ignores its clear or acknowledge stays visible on `flags` and `irq_req` one edge after the strobe. A wrong clock-enable gate shows up as a flag that appears during a halted-clock pulse. A missing gate on the level request shows as a request raised while the clock is stopped. Wake errors appear at the ports immediately, because `wake_req` has no register on its path.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;

endpackage

// File: rtl/eis_rst_sync.sv
module eis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/eis_pin_sync.sv
module eis_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic pin_in,
  output logic pin_now,
  output logic pin_prev
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    stage_d = stage_q;
    prev_d  = prev_q;
    if (clk_en) begin
      stage_d = {stage_q[STAGES-2:0], pin_in};
      prev_d  = stage_q[LAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      stage_q <= stage_d;
      prev_q  <= prev_d;
    end
  end

  assign pin_now  = stage_q[LAST];
  assign pin_prev = prev_q;

endmodule

// File: rtl/eis_sense_cell.sv
module eis_sense_cell
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clk_en,
  input  logic   pin_now,
  input  logic   pin_prev,
  input  sense_t mode,
  input  logic   enable,
  input  logic   clr,
  input  logic   ack,
  output logic   flag,
  output logic   req
);

  logic flag_q;
  logic flag_d;
  logic rise;
  logic fall;
  logic hit;
  logic set_ev;
  logic level_req;

  always_comb begin
    rise = pin_now & ~pin_prev;
    fall = ~pin_now & pin_prev;
    unique case (mode)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
    set_ev = clk_en & enable & hit;
    if (set_ev)          flag_d = 1'b1;
    else if (clr || ack) flag_d = 1'b0;
    else                 flag_d = flag_q;
    level_req = (mode == SENSE_LOW) & enable & clk_en & ~pin_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign req  = level_req | (enable & flag_q);

endmodule

// File: rtl/eis_wake.sv
module eis_wake
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0]   pin_raw,
  input  logic [2*NUM_PINS-1:0] sense_mode,
  input  logic [NUM_PINS-1:0]   irq_enable,
  output logic                  wake_req
);

  logic [NUM_PINS-1:0] low_hit;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hit
    assign low_hit[i] = irq_enable[i] & ~pin_raw[i] &
                        (sense_t'(sense_mode[2*i +: 2]) == SENSE_LOW);
  end

  assign wake_req = |low_hit;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_clk_en,
  input  logic [NUM_PINS-1:0]   pin_raw,
  input  logic [2*NUM_PINS-1:0] sense_mode,
  input  logic [NUM_PINS-1:0]   irq_enable,
  input  logic [NUM_PINS-1:0]   flag_clear,
  input  logic [NUM_PINS-1:0]   irq_ack,
  output logic [NUM_PINS-1:0]   flags,
  output logic [NUM_PINS-1:0]   irq_req,
  output logic                  wake_req
);

  logic                rst_n_int;
  logic [NUM_PINS-1:0] pin_now;
  logic [NUM_PINS-1:0] pin_prev;

  eis_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    eis_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .clk_en   (io_clk_en),
      .pin_in   (pin_raw[i]),
      .pin_now  (pin_now[i]),
      .pin_prev (pin_prev[i])
    );

    eis_sense_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .clk_en   (io_clk_en),
      .pin_now  (pin_now[i]),
      .pin_prev (pin_prev[i]),
      .mode     (sense_t'(sense_mode[2*i +: 2])),
      .enable   (irq_enable[i]),
      .clr      (flag_clear[i]),
      .ack      (irq_ack[i]),
      .flag     (flags[i]),
      .req      (irq_req[i])
    );
  end

  eis_wake #(.NUM_PINS(NUM_PINS)) u_wake (
    .pin_raw    (pin_raw),
    .sense_mode (sense_mode),
    .irq_enable (irq_enable),
    .wake_req   (wake_req)
  );

endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
  parameter int NUM_PINS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  io_clk_en,
  input logic [NUM_PINS-1:0]   pin_raw,
  input logic [2*NUM_PINS-1:0] sense_mode,
  input logic [NUM_PINS-1:0]   irq_enable,
  input logic [NUM_PINS-1:0]   flag_clear,
  input logic [NUM_PINS-1:0]   irq_ack,
  input logic [NUM_PINS-1:0]   flags,
  input logic [NUM_PINS-1:0]   irq_req,
  input logic                  wake_req
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R4: a disabled pin with a clear flag cannot gain one
    a_r4_disabled_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !irq_enable[i]) |=> !flags[i]);

    // R5: no edge is captured while the I/O clock is halted
    a_r5_halt_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !io_clk_en) |=> !flags[i]);

    // R3: with no set possible, a clear strobe empties the flag
    a_r3_clear_halted: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_clear[i] || irq_ack[i]) && !io_clk_en) |=> !flags[i]);

    // R2: a level-mode pin never gains a flag
    a_r2_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> ($past(sense_mode[2*i +: 2]) != 2'b00));

    // R7: a level-mode request requires the running clock and the enable
    a_r7_level_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[i] && !flags[i]) |-> (io_clk_en && irq_enable[i]));
  end

  // R6: wake only when an enabled raw pin is low
  a_r6_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ((irq_enable & ~pin_raw) != '0));

endmodule

bind ext_irq_sense eis_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .io_clk_en  (io_clk_en),
  .pin_raw    (pin_raw),
  .sense_mode (sense_mode),
  .irq_enable (irq_enable),
  .flag_clear (flag_clear),
  .irq_ack    (irq_ack),
  .flags      (flags),
  .irq_req    (irq_req),
  .wake_req   (wake_req)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;

  localparam int N = 4;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         io_clk_en = 1'b1;
  logic [N-1:0] pin_raw = '1;
  logic [2*N-1:0] sense_mode = 8'b11_10_01_00; // pin3 rise, pin2 fall, pin1 any, pin0 low
  logic [N-1:0] irq_enable = '1;
  logic [N-1:0] flag_clear = '0;
  logic [N-1:0] irq_ack = '0;
  logic [N-1:0] flags;
  logic [N-1:0] irq_req;
  logic         wake_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .pin_raw(pin_raw),
    .sense_mode(sense_mode), .irq_enable(irq_enable), .flag_clear(flag_clear),
    .irq_ack(irq_ack), .flags(flags), .irq_req(irq_req), .wake_req(wake_req)
  );

  // pins, enable, clear, exp flags, exp irq, exp wake
  localparam logic [20:0] VEC [NV] = '{
    {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    {4'b1110, 4'b1111, 4'b0000, 4'b0000, 4'b0001, 1'b1},
    {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b1111, 4'b0000, 4'b0110, 4'b0111, 1'b1},
    {4'b1111, 4'b1111, 4'b0000, 4'b1110, 4'b1110, 1'b0},
    {4'b1111, 4'b1111, 4'b1110, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    {4'b1111, 4'b1111, 4'b0000, 4'b1010, 4'b1010, 1'b0},
    {4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b1011, 4'b0000, 4'b0010, 4'b0011, 1'b1},
    {4'b0000, 4'b1111, 4'b0010, 4'b0000, 4'b0001, 1'b1},
    {4'b1111, 4'b1111, 4'b0000, 4'b1010, 4'b1010, 1'b0},
    {4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 1'b0}
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    ticks(3);
    check("R8 flags in reset", flags, 4'b0000);
    check("R8 irq in reset", irq_req, 4'b0000);
    check("R8 wake in reset", {3'b000, wake_req}, 4'b0000);
    rst_n = 1'b1;
    ticks(6);
    check("R8 no edge after release", flags, 4'b0000);

    // R1 R2 R3 R4 R6: vector walk
    for (int v = 0; v < NV; v++) begin
      pin_raw    = VEC[v][20:17];
      irq_enable = VEC[v][16:13];
      flag_clear = VEC[v][12:9];
      ticks(1);
      flag_clear = '0;
      ticks(3);
      check($sformatf("R1/R2/R4 vec%0d flags", v), flags, VEC[v][8:5]);
      check($sformatf("R2/R3 vec%0d irq", v), irq_req, VEC[v][4:1]);
      check($sformatf("R6 vec%0d wake", v), {3'b000, wake_req}, {3'b000, VEC[v][0]});
    end

    // R3: acknowledge clears a flag
    pin_raw = 4'b1101;
    ticks(4);
    check("R3 flag before ack", flags, 4'b0010);
    irq_ack = 4'b0010;
    ticks(1);
    irq_ack = '0;
    check("R3 ack clears", flags, 4'b0000);
    check("R3 ack drops irq", irq_req, 4'b0000);

    // R9: set and clear in the same cycle
    pin_raw = 4'b1111;
    ticks(2);
    flag_clear = 4'b0010;
    ticks(1);
    flag_clear = '0;
    check("R9 set wins over clear", flags, 4'b0010);
    flag_clear = '1;
    ticks(1);
    flag_clear = '0;

    // R5 R6 R7: halted I/O clock
    pin_raw = 4'b0111;
    ticks(4);
    flag_clear = '1;
    ticks(1);
    flag_clear = '0;
    io_clk_en = 1'b0;
    pin_raw = 4'b1110;
    #1;
    check("R6 wake while halted", {3'b000, wake_req}, 4'b0001);
    ticks(3);
    check("R7 no level irq while halted", irq_req, 4'b0000);
    check("R5 no edge flag while halted", flags, 4'b0000);
    pin_raw = 4'b0111;
    #1;
    check("R6 wake drops with level", {3'b000, wake_req}, 4'b0000);
    ticks(1);
    io_clk_en = 1'b1;
    ticks(5);
    check("R5 halted pulse missed", flags, 4'b0000);
    check("R7 vanished level gives no irq", irq_req, 4'b0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule